// File: doc/BRIEF.md
# Colour Subcarrier Phase Oscillator with Atomic Word Load

This block generates the running colour-subcarrier phase used by an analog video encoder. A 32-bit phase increment is added to a 32-bit accumulator on each pixel clock (27 MHz nominal) while the run input is high. The most significant accumulator bits leave the block as the phase that a later sine stage turns into a subcarrier.

The increment is loaded through a byte-wide register write port. It is spread over four adjacent subaddresses, with the least significant byte at 0x8C and the most significant at 0x8F. Each write goes into a shadow copy of the word. The running increment is replaced only after the four bytes arrive in ascending order. The replacement happens in one step, so the accumulator never sees a word that holds some old bytes and some new ones. A synchronous clear input returns the phase to zero and leaves the increment as it was.

The values 0x21F07C1F (bytes 1F, 7C, F0, 21) and 0x2A098ACB (bytes CB, 8A, 09, 2A) are the usual increments for 525-line and 625-line colour systems. The first is loaded at reset.

Top module: `subcarrier_nco`

## Requirements
- R1: After reset the phase output is zero and the running increment equals 0x21F07C1F, the 525-line value.
- R2: A write to subaddress 0x8C+i, with i from 0 to 3, stores its data as byte i of the shadow word. Byte 0 is bits 7:0 and byte 3 is bits 31:24.
- R3: Writes that stop after byte 0, 1 or 2 leave the running increment unchanged for as long as no byte-3 commit follows.
- R4: After the bytes 0, 1, 2 and 3 are written in that order, the new word is used as the increment from the clock after the byte-3 strobe. The clock at which the strobe is sampled still adds the old word.
- R5: A byte written out of order restarts the sequence and blocks the commit. A write of byte 0 always begins a new sequence, even in the middle of an unfinished one.
- R6: Writes to subaddresses outside 0x8C to 0x8F change neither the shadow word nor the sequence in progress.
- R7: With run high, the accumulator adds the increment once per clock and wraps modulo 2^32. With run low, it holds its value.
- R8: The phase output carries the top OUT_W bits of the accumulator (bits 31:16 by default).
- R9: The clear input sets the accumulator to zero on the next clock, takes priority over run, and keeps the running increment.
- R10: The byte sequence CB, 8A, 09, 2A makes the increment 0x2A098ACB, the 625-line value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe, one clock per byte |
| wr_addr | input | ADDR_W (8) | Register subaddress |
| wr_data | input | 8 | Register write data |
| run_en | input | 1 | Advances the accumulator when high |
| phase_clr | input | 1 | Synchronous clear of the phase accumulator |
| phase_out | output | OUT_W (16) | Top bits of the phase accumulator |

## Verification
A table of full-word loads drives the accumulator with the two broadcast increments, with all-ones, with one and with the top bit alone. These patterns separate byte placement (R2) from wrap behaviour and from the choice of output bits. Directed sequences then cover a load left unfinished, a byte skipped, a byte 1 repeated, a fresh byte 0 in the middle of a sequence, and foreign subaddresses written in the middle of a sequence. Each of these yields a different final increment, so a commit that should not happen, or one that should happen but does not, shows up in the phase. Clear while running and holding with run low complete the set.

// File: rtl/snco_pkg.sv
package snco_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = WORD_W / BYTE_W;
    localparam int IDX_W   = $clog2(N_BYTES);

    localparam logic [WORD_W-1:0] WORD_525 = 32'h21F07C1F;
    localparam logic [WORD_W-1:0] WORD_625 = 32'h2A098ACB;

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } byte_wr_t;

    function automatic logic [IDX_W-1:0] last_idx();
        return IDX_W'(N_BYTES - 1);
    endfunction

endpackage

// File: rtl/snco_seq_track.sv
module snco_seq_track
    import snco_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h8C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output byte_wr_t          bw,
    output logic              commit
);

    logic [ADDR_W-1:0] offset;
    logic [IDX_W-1:0]  expect_q;

    always_comb begin
        offset  = wr_addr - BASE_ADDR;
        bw.hit  = wr_en && (offset < ADDR_W'(N_BYTES));
        bw.idx  = offset[IDX_W-1:0];
        bw.data = wr_data;
        commit  = bw.hit && (bw.idx == last_idx()) && (expect_q == last_idx());
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            expect_q <= '0;
        end else if (bw.hit) begin
            if (bw.idx == expect_q)
                expect_q <= (bw.idx == last_idx()) ? '0 : expect_q + IDX_W'(1);
            else if (bw.idx == '0)
                expect_q <= IDX_W'(1);
            else
                expect_q <= '0;
        end
    end

    // R5: a byte other than the expected one or byte 0 drops the sequence
    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (bw.hit && bw.idx != expect_q && bw.idx != '0) |=> (expect_q == '0));

    // R6: foreign subaddresses leave the tracker untouched
    assert_foreign_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (!bw.hit) |=> $stable(expect_q));

    // R4: a commit ends the sequence
    assert_commit_ends_R4: assert property (@(posedge clk) disable iff (rst)
        commit |=> (expect_q == '0));

endmodule

// File: rtl/snco_word_regs.sv
module snco_word_regs
    import snco_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_WORD = WORD_525
) (
    input  logic              clk,
    input  logic              rst,
    input  byte_wr_t          bw,
    input  logic              commit,
    output logic [WORD_W-1:0] active
);

    logic [WORD_W-1:0] shadow_q;
    logic [WORD_W-1:0] active_q;
    logic [WORD_W-1:0] staged;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                shadow_q[g*BYTE_W +: BYTE_W] <= RESET_WORD[g*BYTE_W +: BYTE_W];
            else if (bw.hit && bw.idx == IDX_W'(g))
                shadow_q[g*BYTE_W +: BYTE_W] <= bw.data;
        end
    end

    always_comb begin
        staged = shadow_q;
        staged[WORD_W-1 -: BYTE_W] = bw.data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= RESET_WORD;
        else if (commit)
            active_q <= staged;
    end

    assign active = active_q;

    // R3: without a commit the running word does not move
    assert_active_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!commit) |=> $stable(active_q));

    // R1: reset loads the default word
    assert_reset_word_R1: assert property (@(posedge clk)
        rst |=> (active_q == RESET_WORD));

    // R2: only a hit write changes the shadow copy
    assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!bw.hit) |=> $stable(shadow_q));

endmodule

// File: rtl/snco_phase_acc.sv
module snco_phase_acc
    import snco_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              phase_clr,
    input  logic [WORD_W-1:0] inc,
    output logic [OUT_W-1:0]  phase_out
);

    logic [WORD_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || phase_clr)
            acc_q <= '0;
        else if (run_en)
            acc_q <= acc_q + inc;
    end

    assign phase_out = acc_q[WORD_W-1 -: OUT_W];

    // R9: clear wins over run
    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
        phase_clr |=> (acc_q == '0));

    // R7: idle accumulator holds
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !phase_clr) |=> $stable(acc_q));

endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
    import snco_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h8C,
    parameter logic [31:0]       RESET_WORD = 32'h21F07C1F,
    parameter int                OUT_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              run_en,
    input  logic              phase_clr,
    output logic [OUT_W-1:0]  phase_out
);

    byte_wr_t          bw;
    logic              commit;
    logic [WORD_W-1:0] active;

    snco_seq_track #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_track (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bw      (bw),
        .commit  (commit)
    );

    snco_word_regs #(
        .RESET_WORD (RESET_WORD)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .bw     (bw),
        .commit (commit),
        .active (active)
    );

    snco_phase_acc #(
        .OUT_W (OUT_W)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .phase_clr (phase_clr),
        .inc       (active),
        .phase_out (phase_out)
    );

    // R4: a commit always comes from a byte-3 write
    assert_commit_on_last_R4: assert property (@(posedge clk) disable iff (rst)
        commit |-> (bw.hit && bw.idx == last_idx()));

endmodule

// File: tb/test_subcarrier_nco.sv
module test_subcarrier_nco;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic        run_en = 1'b0;
    logic        phase_clr = 1'b0;
    logic [15:0] phase_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_acc = 32'h0;
    logic [31:0] m_inc = 32'h21F07C1F;

    localparam logic [31:0] VEC [5] = '{
        32'h2A098ACB, 32'hFFFFFFFF, 32'h00000001, 32'h80000000, 32'h21F07C1F
    };

    always #10 clk = ~clk;

    subcarrier_nco i_subcarrier_nco (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .run_en    (run_en),
        .phase_clr (phase_clr),
        .phase_out (phase_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, model after posedge, compare
    task automatic tick(input string tag, input logic we, input logic [7:0] a,
                        input logic [7:0] d, input logic run, input logic clr,
                        input logic do_commit, input logic [31:0] new_inc);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; run_en = run; phase_clr = clr;
        @(posedge clk);
        #5;
        if (clr) m_acc = 32'h0;
        else if (run) m_acc = m_acc + m_inc;
        if (do_commit) m_inc = new_inc;
        check(tag, phase_out, m_acc[31:16]);
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d,
                      input logic do_commit, input logic [31:0] new_inc);
        tick(tag, 1'b1, a, d, 1'b1, 1'b0, do_commit, new_inc);
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic load(input string tag, input logic [31:0] w);
        for (int b = 0; b < 4; b++)
            wr(tag, 8'h8C + 8'(b), w[b*8 +: 8], b == 3, w);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset phase", phase_out, 16'h0);
        run("R1 default word 525-line", 40);

        // table of full-word loads
        for (int v = 0; v < 5; v++) begin
            load("R4 table load", VEC[v]);
            run("R7 R8 R2 table run", 30);
        end

        // R10: 625-line bytes
        wr("R10 byte0", 8'h8C, 8'hCB, 1'b0, 32'h0);
        wr("R10 byte1", 8'h8D, 8'h8A, 1'b0, 32'h0);
        wr("R10 byte2", 8'h8E, 8'h09, 1'b0, 32'h0);
        wr("R10 byte3", 8'h8F, 8'h2A, 1'b1, 32'h2A098ACB);
        run("R10 625-line run", 20);

        // R3: unfinished load
        wr("R3 partial b0", 8'h8C, 8'h11, 1'b0, 32'h0);
        wr("R3 partial b1", 8'h8D, 8'h22, 1'b0, 32'h0);
        wr("R3 partial b2", 8'h8E, 8'h33, 1'b0, 32'h0);
        run("R3 old word kept", 40);

        // R5: skipped byte blocks commit, later bytes do not finish it
        wr("R5 b0", 8'h8C, 8'h01, 1'b0, 32'h0);
        wr("R5 b1", 8'h8D, 8'h02, 1'b0, 32'h0);
        wr("R5 skip to b3", 8'h8F, 8'h7F, 1'b0, 32'h0);
        wr("R5 b2 after restart", 8'h8E, 8'h03, 1'b0, 32'h0);
        wr("R5 b3 after restart", 8'h8F, 8'h04, 1'b0, 32'h0);
        run("R5 no commit", 30);

        // R5: repeated byte 1 restarts
        wr("R5 rep b0", 8'h8C, 8'h10, 1'b0, 32'h0);
        wr("R5 rep b1", 8'h8D, 8'h20, 1'b0, 32'h0);
        wr("R5 rep b1 again", 8'h8D, 8'h30, 1'b0, 32'h0);
        wr("R5 rep b2", 8'h8E, 8'h40, 1'b0, 32'h0);
        wr("R5 rep b3", 8'h8F, 8'h50, 1'b0, 32'h0);
        run("R5 rep no commit", 20);

        // R5: fresh byte 0 mid-sequence starts over and commits
        wr("R5 fresh b0", 8'h8C, 8'hAA, 1'b0, 32'h0);
        wr("R5 fresh b1", 8'h8D, 8'hBB, 1'b0, 32'h0);
        wr("R5 fresh b0 again", 8'h8C, 8'h55, 1'b0, 32'h0);
        wr("R5 fresh b1 again", 8'h8D, 8'h66, 1'b0, 32'h0);
        wr("R5 fresh b2", 8'h8E, 8'h77, 1'b0, 32'h0);
        wr("R5 fresh b3", 8'h8F, 8'h18, 1'b1, 32'h18776655);
        run("R5 fresh commit run", 30);

        // R6: foreign subaddresses interleaved
        wr("R6 b0", 8'h8C, 8'h44, 1'b0, 32'h0);
        wr("R6 foreign 0x8B", 8'h8B, 8'hFF, 1'b0, 32'h0);
        wr("R6 b1", 8'h8D, 8'h33, 1'b0, 32'h0);
        wr("R6 foreign 0x90", 8'h90, 8'hEE, 1'b0, 32'h0);
        wr("R6 b2", 8'h8E, 8'h22, 1'b0, 32'h0);
        wr("R6 foreign 0x00", 8'h00, 8'hDD, 1'b0, 32'h0);
        wr("R6 b3", 8'h8F, 8'h31, 1'b1, 32'h31223344);
        run("R6 commit run", 30);

        // R7: hold with run low
        for (int i = 0; i < 10; i++)
            tick("R7 hold", 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 32'h0);

        // R9: clear while running, word kept
        tick("R9 clear", 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 32'h0);
        run("R9 word kept after clear", 25);

        // R1: reset mid-run returns to default word
        @(negedge clk);
        rst = 1'b1; run_en = 1'b0; wr_en = 1'b0; phase_clr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_acc = 32'h0;
        m_inc = 32'h21F07C1F;
        #1;
        check("R1 reset phase again", phase_out, 16'h0);
        run("R1 default after reset", 30);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule